// File: doc/BRIEF.md
# Posted Column Command Delay Scheduler

This block sits between a memory controller's command front end and the internal command path of a DRAM-style device. Once a bank has been activated, the controller may present a read or write on the very next cycle. The block accepts it at once and issues it internally a programmed number of clocks later, the additive latency.

Because the block accepts a column command early, it also checks the timing at the moment of internal issue. Each issued command carries three flags:

- the activate-to-column minimum would still be broken at issue time;
- the command followed the previous column command too closely;
- the target bank was never activated.

A command with a flag is still issued, so the controller or a checker downstream decides what to do with it. Pending commands travel down a short shift line, so a command can be accepted on every cycle.

Top module: `cas_al_sched`

## Requirements
- R1: The latency setting held by the block is always within 0 to 6. A column command accepted at clock edge E is presented on the issue outputs in the cycle that follows edge E+L, where L is the latency in force at edge E.
- R2: A column command can be accepted on every cycle. Every accepted command is issued exactly once, in acceptance order for a fixed latency, with none lost.
- R3: The issued command carries the write bit, bank and column of the accepted command, unchanged.
- R4: `iss_rcd_err` is 1 when the bank is open and (E + L) − A < TRCD, where A is the edge of the most recent activate to that bank. TRCD defaults to 4.
- R5: `iss_ccd_err` is 1 when an earlier column command was accepted at edge P (since reset) and E − P < TCCD. TCCD defaults to 2, so commands on adjacent edges are flagged and commands two edges apart are not.
- R6: `iss_closed_err` is 1 when the bank has had no activate since reset. An activate on the same edge does not open the bank for that command, and `iss_rcd_err` is 0 for such a command.
- R7: A new value on `al_set` is taken at an edge only if no command is pending and no column command is presented at that edge. Otherwise it is ignored, and it takes effect from the following edge.
- R8: While reset is asserted all issue outputs are 0. Reset discards pending commands, marks every bank closed, forgets the last column command and sets the latency to 0.
- R9: A value of 7 on `al_set` is ignored, and the previous latency is kept.
- R10: A column command presented on the edge right after an activate to its bank is accepted with `iss_closed_err` equal to 0.
- R11: When `iss_valid` is 0, every other issue output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_valid | input | 1 | Activate strobe |
| act_bank | input | 3 | Bank being activated |
| col_valid | input | 1 | Column command strobe |
| col_write | input | 1 | 1 = write, 0 = read |
| col_bank | input | 3 | Bank of the column command |
| col_addr | input | 10 | Column address |
| al_set | input | 3 | Requested additive latency |
| iss_valid | output | 1 | Internal issue strobe |
| iss_write | output | 1 | Write bit of the issued command |
| iss_bank | output | 3 | Bank of the issued command |
| iss_col | output | 10 | Column of the issued command |
| iss_rcd_err | output | 1 | Activate-to-column minimum broken at issue |
| iss_ccd_err | output | 1 | Column-to-column spacing broken |
| iss_closed_err | output | 1 | Bank not activated |

## Verification
The assertions assume that `col_bank` and `act_bank` are within the bank count, and that the inputs are stable and known at each rising edge after reset. They also assume that `al_set` is sampled only through the rule in R7. The bench meets these by driving every input just after a rising edge with values held for the whole cycle, and by limiting bank numbers to 0..7. Reset is asserted and released only between edges. The stimulus includes latency requests of 7 and requests made while commands are pending, because the design must tolerate them, not because the assertions rely on their absence.

// File: rtl/cas_al_sched.sv
module cas_al_sched #(
  parameter int NBANK  = 8,
  parameter int COL_W  = 10,
  parameter int MAX_AL = 6,
  parameter int TRCD   = 4,
  parameter int TCCD   = 2,
  localparam int BANK_W = $clog2(NBANK),
  localparam int AL_W   = $clog2(MAX_AL + 1),
  localparam int ENT_W  = COL_W + BANK_W + 5,
  localparam int AGE_W  = $clog2(TRCD + 1) + 1,
  localparam int GAP_W  = $clog2(TCCD + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_valid,
  input  logic [BANK_W-1:0] act_bank,
  input  logic              col_valid,
  input  logic              col_write,
  input  logic [BANK_W-1:0] col_bank,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [AL_W-1:0]   al_set,
  output logic              iss_valid,
  output logic              iss_write,
  output logic [BANK_W-1:0] iss_bank,
  output logic [COL_W-1:0]  iss_col,
  output logic              iss_rcd_err,
  output logic              iss_ccd_err,
  output logic              iss_closed_err
);

  // entry: {valid, write, bank, col, rcd, ccd, closed}
  logic [ENT_W-1:0]  pipe [MAX_AL];
  logic [ENT_W-1:0]  out_q;
  logic [MAX_AL-1:0] busy;
  logic [AL_W-1:0]   al_q;
  logic [NBANK-1:0]  open_q;
  logic [AGE_W-1:0]  age_q [NBANK];
  logic [GAP_W-1:0]  gap_q;
  logic              seen_q;

  logic             hit_open, rcd_bad, ccd_bad, al_take;
  logic [ENT_W-1:0] new_ent;

  for (genvar i = 0; i < MAX_AL; i++) begin : g_busy
    assign busy[i] = pipe[i][ENT_W-1];
  end

  assign hit_open = open_q[col_bank];
  assign rcd_bad  = hit_open && ((int'(age_q[col_bank]) + 1 + int'(al_q)) < TRCD);
  assign ccd_bad  = seen_q && ((int'(gap_q) + 1) < TCCD);
  assign new_ent  = {1'b1, col_write, col_bank, col_addr, rcd_bad, ccd_bad, !hit_open};
  assign al_take  = (busy == '0) && !col_valid && (int'(al_set) <= MAX_AL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_AL; i++) pipe[i] <= '0;
      out_q <= '0;
    end else begin
      for (int i = 0; i < MAX_AL; i++) begin
        if (col_valid && al_q == AL_W'(i + 1)) pipe[i] <= new_ent;
        else if (i == MAX_AL - 1)              pipe[i] <= '0;
        else                                   pipe[i] <= pipe[i+1];
      end
      out_q <= (col_valid && al_q == '0) ? new_ent : pipe[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_q   <= '0;
      open_q <= '0;
      gap_q  <= '0;
      seen_q <= 1'b0;
      for (int b = 0; b < NBANK; b++) age_q[b] <= '0;
    end else begin
      if (al_take) al_q <= al_set;
      for (int b = 0; b < NBANK; b++) begin
        if (act_valid && act_bank == BANK_W'(b)) begin
          age_q[b]  <= '0;
          open_q[b] <= 1'b1;
        end else if (int'(age_q[b]) < TRCD) begin
          age_q[b] <= age_q[b] + 1'b1;
        end
      end
      if (col_valid) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (int'(gap_q) < TCCD) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assign iss_valid      = out_q[ENT_W-1];
  assign iss_write      = out_q[ENT_W-2];
  assign iss_bank       = out_q[ENT_W-3 -: BANK_W];
  assign iss_col        = out_q[COL_W+2:3];
  assign iss_rcd_err    = out_q[2];
  assign iss_ccd_err    = out_q[1];
  assign iss_closed_err = out_q[0];

  AST_AL_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(al_q) <= MAX_AL); // R1
  AST_AL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy != '0) |=> al_q == $past(al_q)); // R7
  AST_AL0_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && al_q == '0) |=> (iss_valid && iss_col == $past(col_addr) && iss_bank == $past(col_bank) && iss_write == $past(col_write))); // R3
  AST_CLOSED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && al_q == '0 && !open_q[col_bank]) |=> (iss_closed_err && !iss_rcd_err)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !(iss_rcd_err || iss_ccd_err || iss_closed_err || iss_write)); // R11
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy == '0 && !col_valid) |=> !iss_valid); // R2

endmodule

// File: tb/tb_cas_al_sched.sv
module tb_cas_al_sched;
  localparam int TRCD = 4;
  localparam int TCCD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic act_valid = 1'b0, col_valid = 1'b0, col_write = 1'b0;
  logic [2:0] act_bank = '0, col_bank = '0, al_set = '0;
  logic [9:0] col_addr = '0;
  logic iss_valid, iss_write, iss_rcd_err, iss_ccd_err, iss_closed_err;
  logic [2:0] iss_bank;
  logic [9:0] iss_col;

  cas_al_sched dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, al_m = 0, last_col = 0;
  bit seen_col = 0;
  bit open_m [8];
  int act_t [8];
  logic [17:0] exp_q [int];
  string req = "R8";

  task automatic check(input bit ok, input string r, input logic [17:0] got, input logic [17:0] want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at edge %0d: got %h expected %h", r, cyc, got, want);
    end
  endtask

  function automatic logic [17:0] outs();
    return {iss_valid, iss_write, iss_bank, iss_col, iss_rcd_err, iss_ccd_err, iss_closed_err};
  endfunction

  task automatic tick(input bit a, input int ab, input bit c, input bit w, input int cb, input int ca);
    logic [17:0] want;
    bit pending, closed, rcd, ccd;
    act_valid = a; act_bank = 3'(ab);
    col_valid = c; col_write = w; col_bank = 3'(cb); col_addr = 10'(ca);
    @(posedge clk);
    cyc++;
    pending = 0;
    foreach (exp_q[k]) if (k >= cyc) pending = 1;
    if (c) begin
      closed = !open_m[cb];
      rcd = !closed && (cyc + al_m - act_t[cb] < TRCD);
      ccd = seen_col && (cyc - last_col < TCCD);
      exp_q[cyc + al_m] = {1'b1, w, 3'(cb), 10'(ca), rcd, ccd, closed};
      last_col = cyc; seen_col = 1;
    end
    if (a) begin open_m[ab] = 1; act_t[ab] = cyc; end
    if (!pending && !c && al_set <= 3'd6) al_m = al_set;
    #1;
    want = exp_q.exists(cyc) ? exp_q[cyc] : '0;
    if (exp_q.exists(cyc)) exp_q.delete(cyc);
    check(outs() === want, req, outs(), want);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    act_valid = 0; col_valid = 0;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); cyc++; #1;
      check(outs() === '0, "R8", outs(), '0);
    end
    exp_q.delete();
    foreach (open_m[b]) open_m[b] = 0;
    seen_col = 0; al_m = 0;
    rst_n = 1'b1;
  endtask

  task automatic set_al(input int v);
    al_set = 3'(v);
    idle(8);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    do_reset();
    idle(2);

    req = "R6"; // never-opened bank, and activate on the same edge
    tick(0, 0, 1, 0, 0, 10);
    idle(3);
    tick(1, 1, 1, 1, 1, 11);
    idle(3);

    req = "R10"; // column command on the edge after activate
    tick(1, 2, 0, 0, 0, 0);
    tick(0, 0, 1, 0, 2, 12);
    idle(3);

    req = "R1"; // every latency value
    for (int l = 0; l <= 6; l++) begin
      set_al(l);
      tick(1, l, 0, 0, 0, 0);
      tick(0, 0, 1, l[0], l, 100 + l);
      idle(8);
    end

    req = "R2"; // a command on every cycle
    set_al(3);
    for (int i = 0; i < 10; i++) tick(i == 0, 4, 1, i[0], i % 8, 200 + i);
    idle(8);

    req = "R7"; // change while pending is ignored
    set_al(2);
    al_set = 3'd5;
    tick(1, 5, 1, 0, 5, 300);
    tick(0, 0, 0, 0, 0, 0);
    tick(0, 0, 1, 1, 5, 301);
    idle(8);
    tick(0, 0, 1, 0, 5, 302);
    idle(8);

    req = "R9"; // 7 is not a legal latency
    set_al(1);
    al_set = 3'd7;
    idle(4);
    tick(0, 0, 1, 1, 3, 400);
    idle(8);

    req = "R4"; // activate-to-column boundary
    set_al(2);
    tick(1, 6, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0);
    tick(0, 0, 1, 0, 6, 500);
    idle(8);
    tick(1, 7, 0, 0, 0, 0);
    tick(0, 0, 1, 0, 7, 501);
    idle(8);

    req = "R5"; // column spacing boundary
    tick(0, 0, 1, 0, 6, 600);
    tick(0, 0, 0, 0, 0, 0);
    tick(0, 0, 1, 0, 6, 601);
    tick(0, 0, 1, 0, 6, 602);
    idle(8);

    req = "R3";
    for (int i = 0; i < 8; i++) begin
      tick(0, 0, 1, ~i[0], i, 1023 - i * 37);
      tick(0, 0, 0, 0, 0, 0);
    end
    idle(8);

    req = "R8"; // reset with commands in flight
    set_al(6);
    tick(0, 0, 1, 0, 1, 700);
    tick(0, 0, 1, 1, 2, 701);
    do_reset();
    idle(10);
    tick(0, 0, 1, 0, 1, 702);
    idle(4);

    req = "R11";
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 9) == 0) al_set = 3'($urandom_range(0, 7));
      tick($urandom_range(0, 3) == 0, $urandom_range(0, 7),
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           $urandom_range(0, 7), $urandom_range(0, 1023));
    end
    idle(10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule